// File: doc/BRIEF.md
# MII Receive Error Code Reporter

This block is the last stage on the receive side of a 10/100 Ethernet transceiver's media independent interface. Each receive clock it takes a decoded nibble, a data-valid flag and four error-class flags from the decoder that precedes it. It drives the receive data nibble, the receive valid flag and the receive error flag from registers clocked by that same receive clock.

In 100 Mb/s operation, a cycle with any error flag raises the error output and replaces the data nibble with a code for the most severe class flagged. Codes for a packet error or a link error can be limited to the first cycle of an error run by clearing their repeat-enable inputs. In 10 Mb/s operation no code is substituted. With the serial select input high, data leaves on bit 0 alone and the upper data bits are released through per-bit output enables.

A three-state machine tracks the output currently shown. PASS means no error is reported. SHOW means an error code is on the nibble. MUTE means the error flag is high and the nibble reads zero. Each clock the next state comes from the winning error class, the speed and the current state:
- No flag, or 10 Mb/s operation: the next state is PASS.
- Code-error or premature-end class: the next state is SHOW.
- Packet or link class: the next state is SHOW when the current state is PASS or that class's repeat enable is set, and MUTE otherwise.

Top module: `mii_rx_errcode`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `rxd_out`=0, `rx_dv_out`=0, `rx_er_out`=0 and `rxd_oe` all ones.
- R2: In 100 Mb/s mode (`speed_100`=1) with no error flag, `rxd_out` equals `in_nib` and `rx_er_out`=0, one clock after the inputs are sampled. In every mode `rx_dv_out` equals `in_dv` one clock later.
- R3: In 100 Mb/s mode, a cycle with `err_code` high gives `rx_er_out`=1 and `rxd_out`=4'h5 on the next clock, on every cycle of the run.
- R4: In 100 Mb/s mode, a cycle whose highest flag is `err_prem` gives `rx_er_out`=1 and `rxd_out`=4'h4 on every cycle.
- R5: When several flags are high together, the code shown is that of the highest class, in the order `err_code`, `err_prem`, `err_link`, `err_pkt`.
- R6: A cycle whose highest flag is `err_pkt` gives `rx_er_out`=1. `rxd_out` is 4'h2 if the previous cycle carried no error (the start of a run) or `cfg_rep_pkt`=1, and 4'h0 otherwise.
- R7: A cycle whose highest flag is `err_link` gives `rx_er_out`=1. `rxd_out` is 4'h3 if the previous cycle carried no error or `cfg_rep_link`=1, and 4'h0 otherwise.
- R8: In 10 Mb/s mode (`speed_100`=0), the error flags have no effect: `rx_er_out`=0 and `rxd_out` follows `in_nib`.
- R9: In 10 Mb/s mode with `ser_sel`=1, `rxd_oe`=4'b0001, `rxd_out[0]` follows `in_nib[0]` and `rxd_out[3:1]`=0. In every other case `rxd_oe` is all ones, and `ser_sel` has no effect in 100 Mb/s mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | receive clock |
| rst_n | input | 1 | synchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ser_sel | input | 1 | serial single-bit select (used in 10 Mb/s only) |
| cfg_rep_pkt | input | 1 | repeat enable for packet error codes |
| cfg_rep_link | input | 1 | repeat enable for link error codes |
| in_nib | input | 4 | decoded data nibble |
| in_dv | input | 1 | decoded data valid |
| err_pkt | input | 1 | packet error flag |
| err_link | input | 1 | link error flag |
| err_prem | input | 1 | premature end flag |
| err_code | input | 1 | coding error flag |
| rxd_out | output | 4 | receive data nibble |
| rx_dv_out | output | 1 | receive data valid |
| rx_er_out | output | 1 | receive error |
| rxd_oe | output | 4 | per-bit output enable for the data nibble |

## Verification
Single-class error runs of several cycles, with each repeat enable both set and clear, separate a code held on every cycle from one shown only at the start of a run. Runs with several flags raised together check the priority order. A run that starts with a code error and then drops to a packet error checks that the start-of-run rule follows the run and not the class. The same error flags are then applied in 10 Mb/s mode, with and without serial select, to show that they have no effect there and that the upper bits are released. A long pseudo-random stretch mixes all the inputs, including mid-run mode changes and resets, and is compared every clock with a behavioural model.

// File: rtl/mii_rxerr_pkg.sv
package mii_rxerr_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_SHOW = 2'd1,
        ST_MUTE = 2'd2
    } rx_state_e;

    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_PKT  = 3'd1,
        CLS_LINK = 3'd2,
        CLS_PREM = 3'd3,
        CLS_CODE = 3'd4
    } err_cls_e;

    localparam logic [3:0] CODE_PKT  = 4'h2;
    localparam logic [3:0] CODE_LINK = 4'h3;
    localparam logic [3:0] CODE_PREM = 4'h4;
    localparam logic [3:0] CODE_CODE = 4'h5;

    function automatic logic [3:0] cls_to_code(input err_cls_e cls);
        logic [3:0] c;
        unique case (cls)
            CLS_PKT:  c = CODE_PKT;
            CLS_LINK: c = CODE_LINK;
            CLS_PREM: c = CODE_PREM;
            CLS_CODE: c = CODE_CODE;
            default:  c = 4'h0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mii_rxerr_prio.sv
module mii_rxerr_prio
    import mii_rxerr_pkg::*;
(
    input  logic     err_pkt,
    input  logic     err_link,
    input  logic     err_prem,
    input  logic     err_code,
    output err_cls_e cls
);

    // Highest class wins: code, premature end, link, packet (R5)
    always_comb begin
        if (err_code)      cls = CLS_CODE;
        else if (err_prem) cls = CLS_PREM;
        else if (err_link) cls = CLS_LINK;
        else if (err_pkt)  cls = CLS_PKT;
        else               cls = CLS_NONE;
    end

endmodule

// File: rtl/mii_rxerr_fsm.sv
module mii_rxerr_fsm
    import mii_rxerr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      speed_100,
    input  err_cls_e  cls,
    input  logic      cfg_rep_pkt,
    input  logic      cfg_rep_link,
    output rx_state_e state_q,
    output rx_state_e state_d
);

    // Next-state decision
    always_comb begin
        state_d = ST_PASS;
        if (speed_100) begin
            unique case (cls)
                CLS_CODE, CLS_PREM: state_d = ST_SHOW;
                CLS_PKT:  state_d = (state_q == ST_PASS || cfg_rep_pkt)  ? ST_SHOW : ST_MUTE;
                CLS_LINK: state_d = (state_q == ST_PASS || cfg_rep_link) ? ST_SHOW : ST_MUTE;
                default:  state_d = ST_PASS;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    // R6: packet-only run continuing without repeat must go quiet
    a_r6_pkt_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && cls == CLS_PKT && state_q != ST_PASS && !cfg_rep_pkt)
        |=> state_q == ST_MUTE);

    // R3/R4: severe classes always show their code
    a_r3_severe_show: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && (cls == CLS_CODE || cls == CLS_PREM)) |=> state_q == ST_SHOW);

endmodule

// File: rtl/mii_rxerr_drive.sv
module mii_rxerr_drive
    import mii_rxerr_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_100,
    input  logic             ser_sel,
    input  rx_state_e        state_d,
    input  err_cls_e         cls,
    input  logic [NIB_W-1:0] in_nib,
    input  logic             in_dv,
    output logic [NIB_W-1:0] rxd_out,
    output logic             rx_dv_out,
    output logic             rx_er_out,
    output logic [NIB_W-1:0] rxd_oe
);

    localparam int CODE_W = 4;

    logic             serial_mode;
    logic [NIB_W-1:0] nib_d;

    assign serial_mode = !speed_100 && ser_sel;

    // Output selection from the next state
    always_comb begin
        unique case (state_d)
            ST_SHOW: nib_d = NIB_W'({cls_to_code(cls)});
            ST_MUTE: nib_d = '0;
            default: nib_d = in_nib;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dv_out <= 1'b0;
            rx_er_out <= 1'b0;
        end else begin
            rx_dv_out <= in_dv;
            rx_er_out <= (state_d != ST_PASS);
        end
    end

    // Per-bit data and enable: bit 0 always driven, upper bits released in serial mode
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
        if (b == 0) begin : g_lsb
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rxd_out[b] <= 1'b0;
                    rxd_oe[b]  <= 1'b1;
                end else begin
                    rxd_out[b] <= nib_d[b];
                    rxd_oe[b]  <= 1'b1;
                end
            end
        end else begin : g_upper
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rxd_out[b] <= 1'b0;
                    rxd_oe[b]  <= 1'b1;
                end else begin
                    rxd_out[b] <= serial_mode ? 1'b0 : nib_d[b];
                    rxd_oe[b]  <= !serial_mode;
                end
            end
        end
    end

    // R8: no error reported at 10 Mb/s
    a_r8_no_er_slow: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_100 |=> !rx_er_out);

    // R9: serial mode releases upper bits
    a_r9_serial_oe: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> (rxd_oe == NIB_W'(1)) && (rxd_out[NIB_W-1:1] == '0));

    // R2: valid flag follows input
    a_r2_dv_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rx_dv_out == $past(in_dv));

    // R1: synchronous reset state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rxd_out == '0) && !rx_dv_out && !rx_er_out && (rxd_oe == '1));

    initial begin
        a_code_width: assert (NIB_W >= CODE_W);
    end

endmodule

// File: rtl/mii_rx_errcode.sv
module mii_rx_errcode
    import mii_rxerr_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_100,
    input  logic             ser_sel,
    input  logic             cfg_rep_pkt,
    input  logic             cfg_rep_link,
    input  logic [NIB_W-1:0] in_nib,
    input  logic             in_dv,
    input  logic             err_pkt,
    input  logic             err_link,
    input  logic             err_prem,
    input  logic             err_code,
    output logic [NIB_W-1:0] rxd_out,
    output logic             rx_dv_out,
    output logic             rx_er_out,
    output logic [NIB_W-1:0] rxd_oe
);

    err_cls_e  cls;
    rx_state_e state_q;
    rx_state_e state_d;

    mii_rxerr_prio u_prio (
        .err_pkt  (err_pkt),
        .err_link (err_link),
        .err_prem (err_prem),
        .err_code (err_code),
        .cls      (cls)
    );

    mii_rxerr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .speed_100    (speed_100),
        .cls          (cls),
        .cfg_rep_pkt  (cfg_rep_pkt),
        .cfg_rep_link (cfg_rep_link),
        .state_q      (state_q),
        .state_d      (state_d)
    );

    mii_rxerr_drive #(.NIB_W(NIB_W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_100 (speed_100),
        .ser_sel   (ser_sel),
        .state_d   (state_d),
        .cls       (cls),
        .in_nib    (in_nib),
        .in_dv     (in_dv),
        .rxd_out   (rxd_out),
        .rx_dv_out (rx_dv_out),
        .rx_er_out (rx_er_out),
        .rxd_oe    (rxd_oe)
    );

    // R3: coding error shows 4'h5 with error flag
    a_r3_code_out: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && err_code) |=> rx_er_out && (rxd_out == NIB_W'(4'h5)));

    // R4: premature end (no coding error) shows 4'h4
    a_r4_prem_out: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && err_prem && !err_code) |=> rx_er_out && (rxd_out == NIB_W'(4'h4)));

    // R7: link run start shows 4'h3
    a_r7_link_start: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && err_link && !err_prem && !err_code && !rx_er_out)
        |=> rxd_out == NIB_W'(4'h3));

    // R2: clean 100 Mb/s cycle passes the nibble
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && !err_pkt && !err_link && !err_prem && !err_code)
        |=> !rx_er_out && (rxd_out == $past(in_nib)));

endmodule

// File: tb/test_mii_rx_errcode.sv
module test_mii_rx_errcode;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       speed_100, ser_sel, cfg_rep_pkt, cfg_rep_link;
    logic [3:0] in_nib;
    logic       in_dv, err_pkt, err_link, err_prem, err_code;
    logic [3:0] rxd_out;
    logic       rx_dv_out, rx_er_out;
    logic [3:0] rxd_oe;

    int checks = 0;
    int errors = 0;

    // model state: previous cycle reported an error
    bit m_prev_er = 1'b0;

    always #4 clk = ~clk;

    mii_rx_errcode #(.NIB_W(4)) i_mii_rx_errcode (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .ser_sel(ser_sel),
        .cfg_rep_pkt(cfg_rep_pkt), .cfg_rep_link(cfg_rep_link),
        .in_nib(in_nib), .in_dv(in_dv),
        .err_pkt(err_pkt), .err_link(err_link), .err_prem(err_prem), .err_code(err_code),
        .rxd_out(rxd_out), .rx_dv_out(rx_dv_out), .rx_er_out(rx_er_out), .rxd_oe(rxd_oe)
    );

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // One clock: apply inputs at the falling edge, compare after the rising edge.
    task automatic cyc(input bit rn, input bit spd, input bit ser, input bit rp, input bit rl,
                       input logic [3:0] nib, input bit dv,
                       input bit fp, input bit fl, input bit fe, input bit fc);
        logic [3:0] e_rxd, e_oe;
        bit e_dv, e_er;
        string tag;
        int nflags;
        @(negedge clk);
        rst_n = rn; speed_100 = spd; ser_sel = ser; cfg_rep_pkt = rp; cfg_rep_link = rl;
        in_nib = nib; in_dv = dv; err_pkt = fp; err_link = fl; err_prem = fe; err_code = fc;
        nflags = int'(fp) + int'(fl) + int'(fe) + int'(fc);
        if (!rn) begin
            tag = "R1"; e_rxd = 4'h0; e_dv = 0; e_er = 0; e_oe = 4'hF;
        end else if (!spd) begin
            tag = ser ? "R9" : "R8";
            e_dv = dv; e_er = 0;
            e_rxd = ser ? {3'b000, nib[0]} : nib;
            e_oe = ser ? 4'b0001 : 4'hF;
        end else begin
            e_dv = dv; e_oe = 4'hF;
            if (nflags == 0) begin
                tag = ser ? "R9" : "R2"; e_er = 0; e_rxd = nib;
            end else begin
                e_er = 1;
                if (fc)      begin tag = "R3"; e_rxd = 4'h5; end
                else if (fe) begin tag = "R4"; e_rxd = 4'h4; end
                else if (fl) begin tag = "R7"; e_rxd = (!m_prev_er || rl) ? 4'h3 : 4'h0; end
                else         begin tag = "R6"; e_rxd = (!m_prev_er || rp) ? 4'h2 : 4'h0; end
                if (nflags > 1) tag = "R5";
            end
        end
        @(posedge clk);
        #1;
        checks++;
        if (rxd_out !== e_rxd || rx_dv_out !== e_dv || rx_er_out !== e_er || rxd_oe !== e_oe) begin
            errors++;
            $display("FAIL %s: rxd=%h dv=%b er=%b oe=%b expected rxd=%h dv=%b er=%b oe=%b",
                     tag, rxd_out, rx_dv_out, rx_er_out, rxd_oe, e_rxd, e_dv, e_er, e_oe);
        end
        m_prev_er = e_er;
    endtask

    initial begin
        int lfsr;
        // R1: reset state
        cyc(0,1,0,0,0, 4'hA,1, 0,0,0,0);
        cyc(0,1,1,1,1, 4'hF,1, 1,1,1,1);
        // R2: pass-through patterns
        for (int i = 0; i < 16; i++) cyc(1,1,0,0,0, 4'(i), i[0], 0,0,0,0);
        // R3: code error run
        for (int i = 0; i < 3; i++) cyc(1,1,0,0,0, 4'h9,1, 0,0,0,1);
        cyc(1,1,0,0,0, 4'h7,1, 0,0,0,0);
        // R4: premature end run
        for (int i = 0; i < 3; i++) cyc(1,1,0,0,0, 4'hC,1, 0,0,1,0);
        cyc(1,1,0,0,0, 4'h1,0, 0,0,0,0);
        // R6: packet run, no repeat then repeat
        for (int i = 0; i < 4; i++) cyc(1,1,0,0,0, 4'hE,1, 1,0,0,0);
        cyc(1,1,0,0,0, 4'h0,0, 0,0,0,0);
        for (int i = 0; i < 4; i++) cyc(1,1,0,1,0, 4'hE,1, 1,0,0,0);
        cyc(1,1,0,0,0, 4'h0,0, 0,0,0,0);
        // R7: link run, no repeat then repeat; pkt repeat must not affect link
        for (int i = 0; i < 4; i++) cyc(1,1,0,1,0, 4'hB,1, 0,1,0,0);
        cyc(1,1,0,0,0, 4'h0,0, 0,0,0,0);
        for (int i = 0; i < 4; i++) cyc(1,1,0,0,1, 4'hB,1, 0,1,0,0);
        cyc(1,1,0,0,0, 4'h0,0, 0,0,0,0);
        // R5: priority combinations
        cyc(1,1,0,0,0, 4'h8,1, 1,1,1,1);
        cyc(1,1,0,0,0, 4'h8,1, 1,1,1,0);
        cyc(1,1,0,0,0, 4'h8,1, 1,1,0,0);
        cyc(1,1,0,0,0, 4'h8,1, 1,0,0,1);
        cyc(1,1,0,0,0, 4'h0,0, 0,0,0,0);
        cyc(1,1,0,0,0, 4'h8,1, 1,1,0,0);
        cyc(1,1,0,0,0, 4'h8,1, 1,1,0,0);
        // R6: code error then packet in same run (not a run start)
        cyc(1,1,0,0,0, 4'h8,1, 0,0,0,1);
        cyc(1,1,0,0,0, 4'h8,1, 1,0,0,0);
        cyc(1,1,0,0,0, 4'h0,0, 0,0,0,0);
        // R8: 10 Mb/s ignores error flags
        for (int i = 0; i < 5; i++) cyc(1,0,0,0,0, 4'(3*i+1),1, i[0],i[1],i[2],1);
        // R9: serial mode, and serial select ignored at 100 Mb/s
        for (int i = 0; i < 4; i++) cyc(1,0,1,0,0, 4'(5*i+3),1, 0,0,0,i[0]);
        for (int i = 0; i < 3; i++) cyc(1,1,1,0,0, 4'hD,1, 0,0,0,0);
        cyc(1,1,1,0,0, 4'hD,1, 1,0,0,0);
        // R1: reset during an error run, then packet run restarts
        cyc(1,1,0,0,0, 4'h3,1, 1,0,0,0);
        cyc(0,1,0,0,0, 4'h3,1, 1,0,0,0);
        cyc(1,1,0,0,0, 4'h3,1, 1,0,0,0);
        // mixed pseudo-random stretch
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 0);
            cyc((lfsr[31:27] != 0), (lfsr[26:24] != 0), lfsr[23], lfsr[22], lfsr[21],
                lfsr[3:0], lfsr[4],
                lfsr[5] & lfsr[6], lfsr[7] & lfsr[8], lfsr[9] & lfsr[10] & lfsr[11],
                lfsr[12] & lfsr[13] & lfsr[14]);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule